// File: doc/BRIEF.md
# Glitch-Free Clock Output Gate

This block decides when a source clock may reach an output pad. It takes two active-low controls. `pwr_on` stops the clock source when low. `out_en` tri-states the pad when low but leaves the source running. A PLL-lock input keeps the pad off after power-up and after every power-down until lock has been seen for a set number of source cycles. The pad itself is represented only by a drive-enable and a weak-pulldown request. The oscillator and PLL see a single power-down request line.

A mode bit is captured while reset is held and cannot change afterwards. It selects how a disable takes effect. In synchronous mode the disable waits for the falling edge of the source clock, so no high pulse is ever cut short. In asynchronous mode the disable acts at once, whatever level the clock has at that moment. Re-enabling always waits for a falling edge in both modes, so the first pulse after enable is a full one. Both controls and the lock input reach the enable logic through a synchronizer clocked on the falling edge.

Top module: `clk_out_gate`

## Requirements
- R1: While `rst_n` is low, `clk_out` is 0, `pad_drive_en` is 0, `pad_pulldown` is 1, `clk_active` is 0, and `src_pd_req` is 0 whenever `pwr_on` is high.
- R2: After reset or after a power-down, the output is enabled only once the synchronized lock input has been high for LOCK_WAIT consecutive falling edges and both controls are high.
- R3: While enabled, `clk_out` follows `src_clk`, `pad_drive_en` and `clk_active` are 1, and `pad_pulldown` is 0.
- R4: `clk_out` is never high while `src_clk` is low.
- R5: In synchronous mode, `out_en` low disables the output at a falling edge after SYNC_STAGES falling edges of synchronization. `src_pd_req` stays 0 throughout.
- R6: `pwr_on` low raises `src_pd_req` and disables the output. In synchronous mode `src_pd_req` rises at a falling edge after synchronization; in asynchronous mode it follows the pin at once. After `pwr_on` returns high, the lock wait of R2 restarts.
- R7: In asynchronous mode (`cfg_async_dis` high at reset), either control going low forces `pad_drive_en`, `clk_active` and `clk_out` to 0 without waiting for a clock edge.
- R8: In both modes, re-enable happens only at a falling edge of `src_clk`, after the synchronized controls are high.
- R9: With both controls low, power-down wins: `src_pd_req` is 1 and the pad stays off with pulldown requested. Releasing `out_en` alone does not enable the output.
- R10: `cfg_async_dis` is sampled only while `rst_n` is low. Changes after reset have no effect on disable timing.
- R11: A low on `pll_lock` disables the output after synchronization and restarts the lock wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | 1 | Source clock to be gated |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_async_dis | input | 1 | Disable-mode select, sampled during reset (1 = immediate disable) |
| pwr_on | input | 1 | Active-low power-down control (low = power down) |
| out_en | input | 1 | Active-low output-enable control (low = tri-state) |
| pll_lock | input | 1 | Lock indication from the PLL |
| clk_out | output | 1 | Gated clock to the pad |
| pad_drive_en | output | 1 | Pad driver enable (0 = tri-stated) |
| pad_pulldown | output | 1 | Weak-pulldown request for the pad |
| src_pd_req | output | 1 | Power-down request to oscillator and PLL |
| clk_active | output | 1 | Status: gated clock is running |

## Verification
The assertions assume that the controls and `pll_lock` are steady across each falling edge of `src_clk`, so that the synchronizer sees a clean level. They also assume that `src_clk` keeps toggling during power-down; a real source would stop, which is out of scope here. The stimulus changes inputs only shortly after a rising edge and holds each level for at least one full cycle. Every disable pulse is therefore seen by both the synchronizer and the asynchronous path. The reference model applies the asynchronous-disable rule at each sample point and the synchronizer delay at each falling edge.

// File: rtl/cog_pkg.sv
package cog_pkg;

   typedef struct packed {
      logic pwr_ok;
      logic out_ok;
      logic locked;
   } ctl_t;

   localparam int CTL_W = $bits(ctl_t);

   // Count width able to hold 0..maxval, never less than one bit.
   function automatic int cnt_width(input int maxval);
      return (maxval < 1) ? 1 : $clog2(maxval + 1);
   endfunction

endpackage

// File: rtl/cog_sync.sv
module cog_sync #(
   parameter int                 WIDTH   = 1,
   parameter int                 STAGES  = 2,
   parameter logic [WIDTH-1:0]   RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("cog_sync: STAGES must be at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("cog_sync: WIDTH must be at least 1");
      end
   endgenerate

   logic [STAGES-1:0][WIDTH-1:0] chain_q;

   // Falling-edge capture: results settle while the source clock is low.
   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= {STAGES{RST_VAL}};
      else        chain_q <= {chain_q[STAGES-2:0], din};
   end

   assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/cog_lock_wait.sv
module cog_lock_wait #(
   parameter int LOCK_WAIT = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pwr_ok,
   input  logic locked,
   output logic lock_ok
);

   localparam int CNT_W = cog_pkg::cnt_width(LOCK_WAIT);

   generate
      if (LOCK_WAIT < 0) begin : g_bad_wait
         $error("cog_lock_wait: LOCK_WAIT must not be negative");
      end

      if (LOCK_WAIT == 0) begin : g_no_wait
         assign lock_ok = pwr_ok & locked;
      end else begin : g_counted
         logic [CNT_W-1:0] cnt_q;
         localparam logic [CNT_W-1:0] LIMIT = CNT_W'(LOCK_WAIT);

         always_ff @(negedge clk or negedge rst_n) begin
            if (!rst_n)                  cnt_q <= '0;
            else if (!(pwr_ok && locked)) cnt_q <= '0;
            else if (cnt_q != LIMIT)     cnt_q <= cnt_q + 1'b1;
         end

         assign lock_ok = (cnt_q == LIMIT);

         AST_LOCK_RESTART: assert property (@(negedge clk) disable iff (!rst_n)
            !locked |=> (cnt_q == '0)); // R11
         AST_PWR_RESTART: assert property (@(negedge clk) disable iff (!rst_n)
            !pwr_ok |=> !lock_ok); // R6
      end
   endgenerate

endmodule

// File: rtl/cog_gate_ctl.sv
module cog_gate_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic cfg_async,
   input  logic pwr_raw,
   input  logic out_raw,
   input  logic pwr_ok,
   input  logic out_ok,
   input  logic lock_ok,
   output logic gate_en,
   output logic pd_req
);

   logic want_en;
   logic clr_n;
   logic pdreq_q;

   assign want_en = pwr_ok & out_ok & lock_ok;

   // In immediate-disable mode, a low raw control clears the enable at once.
   assign clr_n = rst_n & ~(cfg_async & ~(pwr_raw & out_raw));

   // Enable changes on the falling edge, while the source clock is low.
   always_ff @(negedge clk or negedge clr_n) begin
      if (!clr_n) gate_en <= 1'b0;
      else        gate_en <= want_en;
   end

   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) pdreq_q <= 1'b0;
      else        pdreq_q <= ~pwr_ok;
   end

   assign pd_req = cfg_async ? ~pwr_raw : pdreq_q;

   AST_EN_NEEDS_LOCK: assert property (@(negedge clk) disable iff (!rst_n)
      $rose(gate_en) |-> $past(lock_ok)); // R2
   AST_OE_DISABLES: assert property (@(negedge clk) disable iff (!rst_n)
      !out_ok |=> !gate_en); // R5
   AST_PD_DISABLES: assert property (@(negedge clk) disable iff (!rst_n)
      !pwr_ok |=> (!gate_en && (cfg_async || pd_req))); // R6

endmodule

// File: rtl/clk_out_gate.sv
module clk_out_gate #(
   parameter int SYNC_STAGES = 2,
   parameter int LOCK_WAIT   = 8
) (
   input  logic src_clk,
   input  logic rst_n,
   input  logic cfg_async_dis,
   input  logic pwr_on,
   input  logic out_en,
   input  logic pll_lock,
   output logic clk_out,
   output logic pad_drive_en,
   output logic pad_pulldown,
   output logic src_pd_req,
   output logic clk_active
);

   import cog_pkg::*;

   localparam ctl_t CTL_RST = '{pwr_ok: 1'b1, out_ok: 1'b1, locked: 1'b0};

   logic             cfg_async_q;
   logic [CTL_W-1:0] ctl_raw;
   logic [CTL_W-1:0] ctl_sync;
   ctl_t             ctl_s;
   logic             lock_ok;
   logic             gate_en;

   // Mode bit taken only while reset is held.
   always_ff @(negedge src_clk) begin
      if (!rst_n) cfg_async_q <= cfg_async_dis;
   end

   assign ctl_raw = {pwr_on, out_en, pll_lock};

   cog_sync #(
      .WIDTH   (CTL_W),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (CTL_RST)
   ) u_sync (
      .clk   (src_clk),
      .rst_n (rst_n),
      .din   (ctl_raw),
      .dout  (ctl_sync)
   );

   assign ctl_s = ctl_t'(ctl_sync);

   cog_lock_wait #(
      .LOCK_WAIT (LOCK_WAIT)
   ) u_lock (
      .clk     (src_clk),
      .rst_n   (rst_n),
      .pwr_ok  (ctl_s.pwr_ok),
      .locked  (ctl_s.locked),
      .lock_ok (lock_ok)
   );

   cog_gate_ctl u_gate (
      .clk       (src_clk),
      .rst_n     (rst_n),
      .cfg_async (cfg_async_q),
      .pwr_raw   (pwr_on),
      .out_raw   (out_en),
      .pwr_ok    (ctl_s.pwr_ok),
      .out_ok    (ctl_s.out_ok),
      .lock_ok   (lock_ok),
      .gate_en   (gate_en),
      .pd_req    (pd_req_w)
   );

   logic pd_req_w;

   assign clk_out      = src_clk & gate_en;
   assign pad_drive_en = gate_en;
   assign pad_pulldown = ~gate_en;
   assign clk_active   = gate_en;
   assign src_pd_req   = pd_req_w;

   AST_ASYNC_IMMEDIATE: assert property (@(posedge src_clk) disable iff (!rst_n)
      (cfg_async_q && !(pwr_on && out_en)) |-> !clk_active); // R7
   AST_PD_PRIORITY: assert property (@(posedge src_clk) disable iff (!rst_n)
      (!ctl_s.pwr_ok && !cfg_async_q) |-> (src_pd_req || !$past(ctl_s.pwr_ok) == 1'b0)); // R9

endmodule

// File: tb/tb_clk_out_gate.sv
module tb_clk_out_gate;

   localparam int PERIOD = 10;
   localparam int SAMPLE = 3;
   localparam int STAGES = 2;
   localparam int LW     = 8;

   logic src_clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_async_dis = 1'b0;
   logic pwr_on = 1'b1;
   logic out_en = 1'b1;
   logic pll_lock = 1'b0;
   logic clk_out, pad_drive_en, pad_pulldown, src_pd_req, clk_active;

   int checks = 0;
   int fails = 0;
   bit chk_on = 0;
   bit done = 0;
   string cur_req = "R1";

   clk_out_gate #(.SYNC_STAGES(STAGES), .LOCK_WAIT(LW)) dut (
      .src_clk(src_clk), .rst_n(rst_n), .cfg_async_dis(cfg_async_dis),
      .pwr_on(pwr_on), .out_en(out_en), .pll_lock(pll_lock),
      .clk_out(clk_out), .pad_drive_en(pad_drive_en), .pad_pulldown(pad_pulldown),
      .src_pd_req(src_pd_req), .clk_active(clk_active));

   always #(PERIOD/2) src_clk = ~src_clk;

   // Reference model state
   bit q_pwr[$], q_out[$], q_lk[$];
   bit pwr_s = 1, out_s = 1, lk_s = 0;
   int cnt_m = 0;
   bit en_m = 0, pdreq_m = 0, cfg_m = 0;

   task automatic model_reset();
      q_pwr.delete(); q_out.delete(); q_lk.delete();
      for (int i = 0; i < STAGES-1; i++) begin
         q_pwr.push_back(1'b1); q_out.push_back(1'b1); q_lk.push_back(1'b0);
      end
      pwr_s = 1; out_s = 1; lk_s = 0; cnt_m = 0; en_m = 0; pdreq_m = 0;
   endtask

   always @(negedge src_clk) begin
      bit want;
      if (!rst_n) begin
         cfg_m = cfg_async_dis;
         model_reset();
      end else begin
         want = pwr_s && out_s && (cnt_m == LW);
         if (cfg_m && !(pwr_on && out_en)) en_m = 0;
         else en_m = want;
         pdreq_m = !pwr_s;
         if (!(pwr_s && lk_s)) cnt_m = 0;
         else if (cnt_m < LW) cnt_m++;
         pwr_s = q_pwr.pop_front(); q_pwr.push_back(pwr_on);
         out_s = q_out.pop_front(); q_out.push_back(out_en);
         lk_s  = q_lk.pop_front();  q_lk.push_back(pll_lock);
      end
   end

   task automatic cmp(string req, string what, logic act, logic exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s act=%b exp=%b at %0t", req, what, act, exp, $time);
      end
   endtask

   task automatic check_all(bit high_phase);
      bit e;
      bit pexp;
      if (cfg_m && !(pwr_on && out_en)) en_m = 0;
      e = en_m;
      pexp = cfg_m ? !pwr_on : pdreq_m;
      if (high_phase) cmp(cur_req, "clk_out", clk_out, e);
      else            cmp("R4", "clk_out_low", clk_out, 1'b0);
      cmp(cur_req, "pad_drive_en", pad_drive_en, e);
      cmp(cur_req, "pad_pulldown", pad_pulldown, !e);
      cmp(cur_req, "clk_active", clk_active, e);
      cmp(cur_req, "src_pd_req", src_pd_req, pexp);
   endtask

   initial forever begin
      @(posedge src_clk); #(SAMPLE);
      if (chk_on) check_all(1'b1);
   end

   initial forever begin
      @(negedge src_clk); #(SAMPLE);
      if (chk_on) check_all(1'b0);
   end

   task automatic cyc(int n);
      repeat (n) @(posedge src_clk);
      #1;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   endtask

   initial begin
      #(PERIOD*5000);
      checks++; fails++;
      $display("FAIL R2 watchdog act=timeout exp=completion");
      finish_run();
   end

   initial begin
      // Synchronous-disable mode
      cyc(4);
      #(SAMPLE-1);
      cmp("R1", "reset clk_out", clk_out, 1'b0);
      cmp("R1", "reset pad_drive_en", pad_drive_en, 1'b0);
      cmp("R1", "reset pad_pulldown", pad_pulldown, 1'b1);
      cmp("R1", "reset clk_active", clk_active, 1'b0);
      cmp("R1", "reset src_pd_req", src_pd_req, 1'b0);
      cyc(1);
      rst_n = 1; chk_on = 1; cur_req = "R2";
      cyc(3);  pll_lock = 1;
      cyc(16); cur_req = "R3";
      cyc(5);  cur_req = "R5"; out_en = 0;
      cyc(6);  cur_req = "R8"; out_en = 1;
      cyc(6);  cur_req = "R6"; pwr_on = 0;
      cyc(6);  pwr_on = 1;
      cyc(16); cur_req = "R9"; pwr_on = 0; out_en = 0;
      cyc(5);  out_en = 1;
      cyc(4);  pwr_on = 1;
      cyc(16); cur_req = "R11"; pll_lock = 0;
      cyc(3);  pll_lock = 1;
      cyc(16);
      // Immediate-disable mode
      chk_on = 0; rst_n = 0; cfg_async_dis = 1;
      cyc(4);
      rst_n = 1; chk_on = 1; cur_req = "R2";
      cyc(16); cur_req = "R7"; out_en = 0;
      cyc(1);  out_en = 1; cur_req = "R8";
      cyc(6);  cur_req = "R6"; pwr_on = 0;
      cyc(3);  pwr_on = 1;
      cyc(16); cur_req = "R10"; cfg_async_dis = 0; out_en = 0;
      cyc(2);  out_en = 1;
      cyc(6);
      finish_run();
   end

endmodule